// File: doc/BRIEF.md
# Bidirectional I/O Port with Optional Filtered Reset Pin

This block is a digital model of a general-purpose bidirectional I/O port whose pin count is set by a parameter. Software-visible state is a per-pin output-data register and a per-pin direction register. Pad-side outputs are the drive value, the drive enable and the pull-up enable, and pad levels come back in through a two-flop synchroniser. A pin whose direction bit is 0 is an input. On such a pin, a data bit of 1 turns on its pull-up.

Register access uses a plain single-cycle bus: a 2-bit select, a write strobe, write data and combinational read data. No handshake exists, so a write is taken on every rising edge where the strobe is high. The port releases every pad drive as soon as the active-low reset goes low, without waiting for a clock edge.

A static configuration input can turn the topmost pin into an active-low external reset input. In that mode the pin is never driven and its pull-up stays on. A filter asserts a reset request only when the synchronised pin stays low for more than `MIN_LOW` consecutive cycles. Shorter low pulses are ignored.

Top module: `gpio_port`

## Requirements
- R1: After reset, with the reset-pin mode off, the data and direction registers read 0, and pad_oe, pad_out, pad_pu and reset_out are all 0.
- R2: While rst_n is low, pad_oe is all zeros immediately, with no clock edge needed.
- R3: Select code 0 accesses the data register and code 1 the direction register. A write is visible on rd_data from the next cycle. Code 2 reads the synchronised pin levels and ignores writes. Code 3 reads 0.
- R4: pad_oe[i] equals direction bit i. pad_out[i] equals data bit i when direction bit i is 1, and is 0 otherwise.
- R5: pad_pu[i] is 1 exactly when direction bit i is 0 and data bit i is 1. The reset pin in R7 is the only exception.
- R6: A pad level change that is set up before a rising edge is visible on rd_data with code 2 after the second rising edge, and not after the first.
- R7: With cfg_rst_mode = 1, the top pin (bit WIDTH-1) has pad_oe = 0, pad_out = 0 and pad_pu = 1. Its data and direction bits read 0, and writes to those bits are ignored.
- R8: With cfg_rst_mode = 1, a low on the top pad held for MIN_LOW+1 rising edges asserts reset_out after the (MIN_LOW+2)-th edge, and not before.
- R9: With cfg_rst_mode = 1, a low pulse of MIN_LOW edges or fewer never asserts reset_out. A single high cycle restarts the count.
- R10: reset_out falls after the second rising edge once the top pad returns high.
- R11: With cfg_rst_mode = 0, reset_out stays 0 whatever the top pad does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rst_mode | input | 1 | Static: 1 turns the top pin into a filtered reset input |
| addr | input | 2 | Register select (0 data, 1 direction, 2 pin, 3 none) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Read data for the selected register |
| pad_in | input | WIDTH | Pad levels |
| pad_out | output | WIDTH | Pad drive values |
| pad_oe | output | WIDTH | Pad drive enables |
| pad_pu | output | WIDTH | Pull-up enables |
| reset_out | output | 1 | Filtered reset request from the top pin |

## Verification
The assertions check the following on every cycle:
- drive enables are off whenever reset is low;
- a pin is never driven while disabled;
- pull-up and drive are never on together on one pin;
- the reset pin is released with its pull-up on;
- the low-cycle counter steps by one and clears on a high level;
- writes to the pin address leave both registers unchanged.

The exact edge on which reset_out rises and falls can only be shown by the bench's timed scenarios. The same holds for short pulses and restarts being rejected, and for the two-edge latency of the pin path.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } port_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {W{RST_VAL}};
      hold_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lock_mask,
  input  port_sel_e    sel,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] pin_q,
  output logic [W-1:0] dat_eff,
  output logic [W-1:0] dir_eff,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] dat_q;
  logic [W-1:0] dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      dir_q <= '0;
    end else if (wr_en) begin
      if (sel == SEL_DATA) dat_q <= wr_data & ~lock_mask;
      if (sel == SEL_DIR)  dir_q <= wr_data & ~lock_mask;
    end
  end

  assign dat_eff = dat_q & ~lock_mask;
  assign dir_eff = dir_q & ~lock_mask;

  always_comb begin
    case (sel)
      SEL_DATA: rd_data = dat_eff;
      SEL_DIR:  rd_data = dir_eff;
      SEL_PIN:  rd_data = pin_q;
      default:  rd_data = '0;
    endcase
  end

  // R3: the pin address is read-only
  a_r3_pin_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_PIN) |=> ($stable(dat_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_rst_filter.sv
module gpio_rst_filter #(
  parameter int MIN_LOW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic pin_s,
  output logic reset_out
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] TOP = CW'(MIN_LOW);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!enable || pin_s) cnt <= '0;
    else if (cnt != TOP)       cnt <= cnt + CW'(1);
  end

  assign reset_out = enable && !pin_s && (cnt == TOP);

  // R9: every low cycle below the limit advances the count by exactly one
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !pin_s && cnt != TOP) |=> (cnt == $past(cnt) + CW'(1)));
  // R9: a high level restarts the count
  a_r9_high_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pin_s |=> (cnt == '0));
  // R8: a rising request follows a low level on the previous cycle
  a_r8_rise_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_out) |-> $past(!pin_s));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 7,
  parameter int MIN_LOW = 16,
  parameter bit RST_PIN_CAPABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_rst_mode,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu,
  output logic             reset_out
);
  localparam int TOP_BIT = WIDTH - 1;
  localparam logic [WIDTH-1:0] TOP_MASK = {1'b1, {(WIDTH-1){1'b0}}};

  logic             rst_mode;
  logic [WIDTH-1:0] lock_mask;
  logic [WIDTH-1:0] pin_q;
  logic [WIDTH-1:0] dat_eff;
  logic [WIDTH-1:0] dir_eff;
  port_sel_e        sel;

  assign rst_mode  = RST_PIN_CAPABLE && cfg_rst_mode;
  assign lock_mask = rst_mode ? TOP_MASK : '0;
  assign sel       = port_sel_e'(addr);

  gpio_sync #(.W(WIDTH), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_q)
  );

  gpio_regs #(.W(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .lock_mask(lock_mask), .sel(sel),
    .wr_en(wr_en), .wr_data(wr_data), .pin_q(pin_q),
    .dat_eff(dat_eff), .dir_eff(dir_eff), .rd_data(rd_data)
  );

  generate
    if (RST_PIN_CAPABLE) begin : g_filt
      gpio_rst_filter #(.MIN_LOW(MIN_LOW)) u_filt (
        .clk(clk), .rst_n(rst_n), .enable(rst_mode),
        .pin_s(pin_q[TOP_BIT]), .reset_out(reset_out)
      );
    end else begin : g_nofilt
      assign reset_out = 1'b0;
    end
  endgenerate

  assign pad_oe  = rst_n ? dir_eff : '0;
  assign pad_out = rst_n ? (dat_eff & dir_eff) : '0;
  assign pad_pu  = (dat_eff & ~dir_eff) | lock_mask;

  // R2: drive released whenever reset is low, independent of any clock
  always_comb begin
    if (!rst_n) a_r2_oe_off_in_reset: assert (pad_oe == '0);
  end
  // R4: no value is driven on a disabled pin
  a_r4_no_drive_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);
  // R5: pull-up and drive never together
  a_r5_pu_excl_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);
  // R7: reset pin released with pull-up on
  a_r7_rst_pin_free: assert property (@(posedge clk) disable iff (!rst_n)
    rst_mode |-> (!pad_oe[TOP_BIT] && pad_pu[TOP_BIT]));
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  localparam int W = 7;
  localparam int ML = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_rst_mode = 1'b0;
  logic [1:0]   addr = 2'd3;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic [W-1:0] pad_in = '1;
  logic [W-1:0] pad_out, pad_oe, pad_pu;
  logic         reset_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port #(.WIDTH(W), .MIN_LOW(ML), .RST_PIN_CAPABLE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_rst_mode(cfg_rst_mode), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .reset_out(reset_out)
  );

  // {dir, data, exp_oe, exp_out, exp_pu}
  localparam logic [5*W-1:0] VEC [6] = '{
    {7'h00, 7'h7F, 7'h00, 7'h00, 7'h7F},
    {7'h7F, 7'h55, 7'h7F, 7'h55, 7'h00},
    {7'h0F, 7'h3C, 7'h0F, 7'h0C, 7'h30},
    {7'h70, 7'h1A, 7'h70, 7'h10, 7'h0A},
    {7'h2A, 7'h7F, 7'h2A, 7'h2A, 7'h55},
    {7'h55, 7'h00, 7'h55, 7'h00, 7'h00}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; cfg_rst_mode = mode; pad_in = '1;
    edges(2);
    rst_n = 1'b1;
    edges(3);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r;
    do_reset(1'b0);
    // R1 reset state
    rd(2'd0, r); chk("R1 data", r, '0);
    rd(2'd1, r); chk("R1 dir", r, '0);
    chk("R1 oe", pad_oe, '0);
    chk("R1 pu", pad_pu, '0);
    chk("R1 rst_out", {6'd0, reset_out}, '0);

    // R3 R4 R5 table walk
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] vdir, vdat, eoe, eout, epu;
      {vdir, vdat, eoe, eout, epu} = VEC[k];
      wr(2'd0, vdat);
      wr(2'd1, vdir);
      rd(2'd0, r); chk("R3 data readback", r, vdat);
      rd(2'd1, r); chk("R3 dir readback", r, vdir);
      chk("R4 oe", pad_oe, eoe);
      chk("R4 out", pad_out, eout);
      chk("R5 pu", pad_pu, epu);
    end

    // R3 pin address ignores writes, code 3 reads 0
    wr(2'd0, 7'h33); wr(2'd1, 7'h0C);
    wr(2'd2, 7'h5A);
    rd(2'd0, r); chk("R3 data after pin write", r, 7'h33);
    rd(2'd1, r); chk("R3 dir after pin write", r, 7'h0C);
    rd(2'd3, r); chk("R3 code3", r, '0);

    // R6 two-edge pin latency
    @(negedge clk); pad_in = 7'h25;
    @(negedge clk); rd(2'd2, r); chk("R6 after one edge", r, 7'h7F);
    @(negedge clk); rd(2'd2, r); chk("R6 after two edges", r, 7'h25);

    // R11 gpio mode never requests reset
    pad_in = 7'h00;
    edges(12);
    chk("R11 rst_out", {6'd0, reset_out}, '0);
    pad_in = 7'h7F;

    // R2 asynchronous release
    wr(2'd1, 7'h7F);
    @(negedge clk); #1;
    rst_n = 1'b0; #0.5;
    chk("R2 oe async", pad_oe, '0);
    rst_n = 1'b1;

    // R7 reset-pin mode
    do_reset(1'b1);
    wr(2'd0, 7'h7F); wr(2'd1, 7'h7F);
    rd(2'd0, r); chk("R7 data masked", r, 7'h3F);
    rd(2'd1, r); chk("R7 dir masked", r, 7'h3F);
    chk("R7 oe", pad_oe, 7'h3F);
    chk("R7 out", pad_out, 7'h3F);
    chk("R7 pu", pad_pu, 7'h40);

    // R8 assertion timing
    pad_in[W-1] = 1'b0;
    edges(ML + 1);
    chk("R8 before", {6'd0, reset_out}, '0);
    edges(1);
    chk("R8 asserted", {6'd0, reset_out}, 7'd1);
    // R10 release timing
    pad_in[W-1] = 1'b1;
    edges(1);
    chk("R10 still high", {6'd0, reset_out}, 7'd1);
    edges(1);
    chk("R10 released", {6'd0, reset_out}, '0);

    // R9 pulse of exactly MIN_LOW edges
    edges(3);
    pad_in[W-1] = 1'b0; edges(ML);
    pad_in[W-1] = 1'b1;
    for (int j = 0; j < 4; j++) begin
      edges(1);
      chk("R9 short pulse", {6'd0, reset_out}, '0);
    end
    // R9 restart by one high cycle
    pad_in[W-1] = 1'b0; edges(ML);
    pad_in[W-1] = 1'b1; edges(1);
    pad_in[W-1] = 1'b0; edges(ML);
    chk("R9 restart", {6'd0, reset_out}, '0);
    pad_in[W-1] = 1'b1;
    edges(4);
    chk("R9 after restart", {6'd0, reset_out}, '0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule